// File: doc/BRIEF.md
# Boundary-Scan Test-Mode Instruction Controller

This block sits behind a four-wire test access port and turns the capture, shift and update strobes of a companion TAP state machine into test behaviour for a bank of I/O pins. It keeps an 8-bit instruction register, checks the parity of each opcode and decodes it. It then selects which data register lies between TDI and TDO, and it decides whether the pins carry the functional path or values from the test logic.

Besides the mandatory bypass, sample/preload and extest instructions, it provides clamp, high-impedance and device identification. It also has four self-test engines that advance once per TCK while the TAP rests in Run-Test/Idle: signature compaction of the input pins, a pseudo-random pattern on the outputs, compaction combined with a binary up-count on the outputs, and sample-and-toggle. Every clock is TCK. The pin outputs, the output enable and the test flag are all registered.

Top module: `scan_mode_ctrl`

## Requirements
- R1: A capture_ir cycle loads 8'h81 into the instruction shift register. Each shift_ir cycle presents bit 0 on tdo and moves tdi into bit 7. An update_ir cycle makes the shifted value the active instruction.
- R2: The valid opcodes all have even parity: extest 8'h00, sample 8'h03, clamp 8'h05, highz 8'h06, idcode 8'h09, signature 8'h0A, pattern 8'h0C, count 8'h0F, toggle 8'h11 and bypass 8'hFF. Any odd-parity or unassigned opcode acts as bypass. test_mode is 1 only for extest, clamp, highz, signature, pattern, count and toggle.
- R3: Under bypass, clamp and highz, the 1-bit bypass register is selected. It captures 0, so a scan of n bits returns 0 followed by the first n-1 tdi bits.
- R4: idcode selects a 32-bit register that captures ID_VALUE. It shifts out LSB first.
- R5: sample, extest and toggle select a 2*PINS-bit boundary register. On capture, bits [PINS-1:0] take pin_in and bits [2*PINS-1:PINS] take pin_out. It shifts toward bit 0, which drives tdo. On update, bits [2*PINS-1:PINS] are copied into the output latch. Under sample, test_mode stays 0.
- R6: Under extest, pin_out equals the output latch, pin_oe is 1 and test_mode is 1.
- R7: Under clamp, the pins are driven exactly as under extest, while the DR path is the bypass register.
- R8: Under highz, pin_oe is 0 and test_mode is 1.
- R9: signature, pattern and count select an 18-bit pattern register. Under signature, each Run-Test/Idle cycle sets s to {s[16:0], s[17]^s[10]} ^ pin_in. pin_out holds the output latch.
- R10: Under pattern, each Run-Test/Idle cycle sets s to {s[16:0], s[17]^s[10]}, except that a zero state becomes 1. pin_out shows s one clock later.
- R11: Under count, each Run-Test/Idle cycle compacts pin_in as in R9 and increments an 18-bit counter. pin_out shows the counter one clock later. Reset leaves the counter at 0 and the pattern register at 1.
- R12: Under toggle, each Run-Test/Idle cycle inverts the output latch and loads pin_in into boundary bits [PINS-1:0].
- R13: When test_mode is 0, pin_out and pin_oe follow func_out and func_oe one clock later, whatever the TAP strobes do. Reset leaves test_mode and the outputs at 0, with bypass active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock (TCK) |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial test data in |
| capture_ir | input | 1 | TAP is in Capture-IR |
| shift_ir | input | 1 | TAP is in Shift-IR |
| update_ir | input | 1 | TAP is in Update-IR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| run_idle | input | 1 | TAP is in Run-Test/Idle |
| pin_in | input | PINS | Values seen at the input pins |
| func_out | input | PINS | Functional output data |
| func_oe | input | 1 | Functional output enable |
| tdo | output | 1 | Serial test data out |
| pin_out | output | PINS | Registered value driven to the pins |
| pin_oe | output | 1 | Registered pin output enable |
| test_mode | output | 1 | Registered flag: the test logic owns the pins |

## Verification
Some behaviour is checked by the bound checker on every clock. It covers the instruction capture value, the rule that an odd-parity instruction never raises test_mode, and disabled outputs under highz. It also checks that the pattern register never reaches zero under pattern, the counter step and latch inversion per idle cycle, and the one-clock pass-through of the functional path while test_mode is low. Other behaviour shows only in the bench's scenarios. These are the serial lengths and contents of each data register, the exact signature and pseudo-random sequences, preload-then-extest ordering, and the full decode of all 256 opcodes.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int IR_W = 8;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h81;

  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h03;
  localparam logic [IR_W-1:0] OP_CLAMP  = 8'h05;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 8'h06;
  localparam logic [IR_W-1:0] OP_IDCODE = 8'h09;
  localparam logic [IR_W-1:0] OP_SIG    = 8'h0A;
  localparam logic [IR_W-1:0] OP_PRPG   = 8'h0C;
  localparam logic [IR_W-1:0] OP_COUNT  = 8'h0F;
  localparam logic [IR_W-1:0] OP_TOGGLE = 8'h11;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

  typedef enum logic [3:0] {
    M_BYPASS, M_EXTEST, M_SAMPLE, M_CLAMP, M_HIGHZ,
    M_IDCODE, M_SIG, M_PRPG, M_COUNT, M_TOGGLE
  } mode_e;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR, DR_PAT} dr_e;

  function automatic mode_e decode(input logic [IR_W-1:0] op);
    if (^op) return M_BYPASS;
    case (op)
      OP_EXTEST: return M_EXTEST;
      OP_SAMPLE: return M_SAMPLE;
      OP_CLAMP:  return M_CLAMP;
      OP_HIGHZ:  return M_HIGHZ;
      OP_IDCODE: return M_IDCODE;
      OP_SIG:    return M_SIG;
      OP_PRPG:   return M_PRPG;
      OP_COUNT:  return M_COUNT;
      OP_TOGGLE: return M_TOGGLE;
      default:   return M_BYPASS;
    endcase
  endfunction

  function automatic dr_e dr_of(input mode_e m);
    case (m)
      M_IDCODE:                  return DR_ID;
      M_SAMPLE, M_EXTEST, M_TOGGLE: return DR_BSR;
      M_SIG, M_PRPG, M_COUNT:    return DR_PAT;
      default:                   return DR_BYP;
    endcase
  endfunction

  function automatic logic is_test(input mode_e m);
    return m inside {M_EXTEST, M_CLAMP, M_HIGHZ, M_SIG, M_PRPG, M_COUNT, M_TOGGLE};
  endfunction
endpackage

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic [IR_W-1:0] sr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= IR_CAPTURE;
      ir_q <= OP_BYPASS;
    end else begin
      if (capture)    sr_q <= IR_CAPTURE;
      else if (shift) sr_q <= {tdi, sr_q[IR_W-1:1]};
      if (update)     ir_q <= sr_q;
    end
  end
endmodule

// File: rtl/scan_pattern.sv
module scan_pattern
  import scan_pkg::*;
#(
  parameter int W     = 18,
  parameter int TAP_A = 17,
  parameter int TAP_B = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         tdi,
  input  logic         step,
  input  mode_e        mode,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pat_q,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] adv;
  logic         fb;

  always_comb begin
    fb  = pat_q[TAP_A] ^ pat_q[TAP_B];
    adv = {pat_q[W-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q <= W'(1);
      cnt_q <= '0;
    end else if (shift_en) begin
      pat_q <= {tdi, pat_q[W-1:1]};
    end else if (step) begin
      case (mode)
        M_SIG:   pat_q <= adv ^ pin_in;
        M_PRPG:  pat_q <= (pat_q == '0) ? W'(1) : adv;
        M_COUNT: begin
          pat_q <= adv ^ pin_in;
          cnt_q <= cnt_q + W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scan_bsr.sv
module scan_bsr #(
  parameter int P = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         update_en,
  input  logic         toggle_step,
  input  logic         tdi,
  input  logic [P-1:0] pin_in,
  input  logic [P-1:0] pin_obs,
  output logic         lsb,
  output logic [P-1:0] upd_q
);
  localparam int BW = 2 * P;
  logic [BW-1:0] sr_q;

  assign lsb = sr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      upd_q <= '0;
    end else begin
      if (capture_en)       sr_q <= {pin_obs, pin_in};
      else if (shift_en)    sr_q <= {tdi, sr_q[BW-1:1]};
      else if (toggle_step) sr_q[P-1:0] <= pin_in;
      if (update_en)        upd_q <= sr_q[BW-1:P];
      else if (toggle_step) upd_q <= ~upd_q;
    end
  end
endmodule

// File: rtl/scan_mode_ctrl.sv
module scan_mode_ctrl
  import scan_pkg::*;
#(
  parameter int          PINS     = 18,
  parameter int          TAP_A    = 17,
  parameter int          TAP_B    = 10,
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h0B52_E02F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tdi,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            run_idle,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] func_out,
  input  logic            func_oe,
  output logic            tdo,
  output logic [PINS-1:0] pin_out,
  output logic            pin_oe,
  output logic            test_mode
);
  logic [IR_W-1:0] ir_q, ir_sr;
  mode_e           mode;
  dr_e             dsel;
  logic            tm;
  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic [PINS-1:0] pat_q, cnt_q, upd_q, drv;
  logic            bsr_lsb, oe_t;

  scan_ir u_ir (
    .clk(clk), .rst(rst), .capture(capture_ir), .shift(shift_ir),
    .update(update_ir), .tdi(tdi), .ir_q(ir_q), .sr_q(ir_sr)
  );

  always_comb begin
    mode = decode(ir_q);
    dsel = dr_of(mode);
    tm   = is_test(mode);
  end

  scan_pattern #(.W(PINS), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_pat (
    .clk(clk), .rst(rst), .shift_en(shift_dr && dsel == DR_PAT), .tdi(tdi),
    .step(run_idle), .mode(mode), .pin_in(pin_in), .pat_q(pat_q), .cnt_q(cnt_q)
  );

  scan_bsr #(.P(PINS)) u_bsr (
    .clk(clk), .rst(rst),
    .capture_en(capture_dr && dsel == DR_BSR),
    .shift_en(shift_dr && dsel == DR_BSR),
    .update_en(update_dr && dsel == DR_BSR),
    .toggle_step(run_idle && mode == M_TOGGLE),
    .tdi(tdi), .pin_in(pin_in), .pin_obs(pin_out),
    .lsb(bsr_lsb), .upd_q(upd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      if (dsel == DR_BYP) begin
        if (capture_dr)    byp_q <= 1'b0;
        else if (shift_dr) byp_q <= tdi;
      end
      if (dsel == DR_ID) begin
        if (capture_dr)    id_q <= ID_VALUE[ID_W-1:0];
        else if (shift_dr) id_q <= {tdi, id_q[ID_W-1:1]};
      end
    end
  end

  always_comb begin
    if (shift_ir) tdo = ir_sr[0];
    else begin
      case (dsel)
        DR_ID:   tdo = id_q[0];
        DR_BSR:  tdo = bsr_lsb;
        DR_PAT:  tdo = pat_q[0];
        default: tdo = byp_q;
      endcase
    end
    case (mode)
      M_PRPG:  drv = pat_q;
      M_COUNT: drv = cnt_q;
      default: drv = upd_q;
    endcase
    oe_t = (mode != M_HIGHZ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out   <= '0;
      pin_oe    <= 1'b0;
      test_mode <= 1'b0;
    end else begin
      pin_out   <= tm ? drv : func_out;
      pin_oe    <= tm ? oe_t : func_oe;
      test_mode <= tm;
    end
  end
endmodule

// File: rtl/scan_mode_ctrl_chk.sv
module scan_mode_ctrl_chk
  import scan_pkg::*;
#(
  parameter int P = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            capture_ir,
  input logic            shift_dr,
  input logic            update_dr,
  input logic            run_idle,
  input logic            tm,
  input logic            test_mode,
  input mode_e           mode,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sr,
  input logic [P-1:0]    pin_out,
  input logic [P-1:0]    func_out,
  input logic            pin_oe,
  input logic [P-1:0]    pat_q,
  input logic [P-1:0]    cnt_q,
  input logic [P-1:0]    upd_q
);
  // R1
  ir_capture_chk: assert property (@(posedge clk) disable iff (rst)
    capture_ir |=> ir_sr == 8'h81);
  // R2
  parity_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (^ir_q) |=> !test_mode);
  // R8
  highz_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_HIGHZ) |=> !pin_oe);
  // R10
  prpg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PRPG && run_idle && !shift_dr) |=> pat_q != '0);
  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_COUNT && run_idle && !shift_dr) |=> cnt_q == P'($past(cnt_q) + 1'b1));
  // R12
  toggle_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_TOGGLE && run_idle && !shift_dr && !update_dr) |=> upd_q == ~$past(upd_q));
  // R13
  normal_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !tm |=> pin_out == $past(func_out));
endmodule

bind scan_mode_ctrl scan_mode_ctrl_chk #(.P(PINS)) u_chk (
  .clk(clk), .rst(rst), .capture_ir(capture_ir), .shift_dr(shift_dr),
  .update_dr(update_dr), .run_idle(run_idle), .tm(tm), .test_mode(test_mode),
  .mode(mode), .ir_q(ir_q), .ir_sr(ir_sr), .pin_out(pin_out),
  .func_out(func_out), .pin_oe(pin_oe), .pat_q(pat_q), .cnt_q(cnt_q),
  .upd_q(upd_q)
);

// File: tb/sim_scan_mode_ctrl.sv
module sim_scan_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P = 18;
  localparam logic [31:0] ID = 32'h0B52_E02F;

  logic clk = 1'b0, rst = 1'b1, tdi = 1'b0;
  logic capture_ir = 0, shift_ir = 0, update_ir = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, run_idle = 0;
  logic [P-1:0] pin_in = '0, func_out = '0;
  logic func_oe = 1'b0;
  logic tdo, pin_oe, test_mode;
  logic [P-1:0] pin_out;

  int checks = 0, fails = 0;

  scan_mode_ctrl #(.PINS(P), .ID_VALUE(ID)) u0 (
    .clk(clk), .rst(rst), .tdi(tdi), .capture_ir(capture_ir), .shift_ir(shift_ir),
    .update_ir(update_ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .run_idle(run_idle), .pin_in(pin_in),
    .func_out(func_out), .func_oe(func_oe), .tdo(tdo), .pin_out(pin_out),
    .pin_oe(pin_oe), .test_mode(test_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [P-1:0] lfsr(input logic [P-1:0] s);
    return {s[P-2:0], s[17] ^ s[10]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
    capture_ir = 1; cyc(); capture_ir = 0;
    shift_ir = 1;
    for (int i = 0; i < 8; i++) begin
      tdi = op[i]; #1 cap[i] = tdo; cyc();
    end
    shift_ir = 0; update_ir = 1; cyc(); update_ir = 0;
    cyc();
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input logic do_cap,
                         output logic [63:0] dout);
    dout = '0;
    if (do_cap) begin capture_dr = 1; cyc(); capture_dr = 0; end
    shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i]; #1 dout[i] = tdo; cyc();
    end
    shift_dr = 0; update_dr = 1; cyc(); update_dr = 0;
    cyc();
  endtask

  task automatic idle_step();
    run_idle = 1; cyc(); run_idle = 0; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] cap;
    logic [63:0] dout;
    logic [P-1:0] s, c, o1, o2, o_exp, pin_last;
    logic exp_tm;
    @(negedge clk);
    func_out = 18'h15A3C; func_oe = 1;
    cyc(); cyc();
    // R13 reset state
    chk("R13 reset pin_out", pin_out, 0);
    chk("R13 reset test_mode", test_mode, 0);
    rst = 0; cyc();
    chk("R13 pass func_out", pin_out, 18'h15A3C);
    chk("R13 pass func_oe", pin_oe, 1);

    // R1 capture value, R5 sample
    load_ir(8'h03, cap);
    chk("R1 ir capture", cap, 8'h81);
    chk("R5 sample test_mode low", test_mode, 0);
    pin_in = 18'h2B6D1;
    o1 = 18'h0F0F3;
    scan_dr(36, {28'h0, o1, 18'h0}, 1, dout);
    chk("R5 input cells", dout[17:0], 18'h2B6D1);
    chk("R5 output cells", dout[35:18], 18'h15A3C);
    chk("R13 pins undisturbed by scan", pin_out, 18'h15A3C);

    // R6 extest with preloaded latch
    func_out = 18'h00777;
    load_ir(8'h00, cap);
    chk("R6 extest pin_out", pin_out, o1);
    chk("R6 extest pin_oe", pin_oe, 1);
    chk("R6 extest test_mode", test_mode, 1);
    o2 = 18'h3C5A1;
    scan_dr(36, {28'h0, o2, 18'h0}, 1, dout);
    chk("R6 extest update", pin_out, o2);

    // R7 clamp, R3 bypass path
    load_ir(8'h05, cap);
    chk("R7 clamp pin_out", pin_out, o2);
    scan_dr(2, 64'h1, 1, dout);
    chk("R3 clamp bypass length", dout[1:0], 2'b10);
    chk("R7 clamp holds after update", pin_out, o2);

    // R8 highz
    load_ir(8'h06, cap);
    chk("R8 highz pin_oe", pin_oe, 0);
    chk("R8 highz test_mode", test_mode, 1);

    // R4 idcode
    load_ir(8'h09, cap);
    scan_dr(32, 64'h0, 1, dout);
    chk("R4 idcode value", dout[31:0], ID);
    chk("R2 idcode test_mode", test_mode, 0);

    // R2 odd parity opcode acts as bypass
    load_ir(8'h01, cap);
    scan_dr(3, 64'h3, 1, dout);
    chk("R2 odd parity bypass", dout[2:0], 3'b110);
    chk("R2 odd parity test_mode", test_mode, 0);

    // R9 signature
    load_ir(8'h0A, cap);
    s = 18'h2D1C7;
    scan_dr(18, {46'h0, s}, 1, dout);
    for (int k = 0; k < 12; k++) begin
      pin_in = P'((k * 18'h1357) ^ 18'h0A5A5);
      run_idle = 1; cyc(); run_idle = 0;
      s = lfsr(s) ^ pin_in;
    end
    cyc();
    chk("R9 signature holds outputs", pin_out, o2);
    scan_dr(18, 64'h0, 1, dout);
    chk("R9 signature value", dout[17:0], s);

    // R10 pattern from zero seed
    load_ir(8'h0C, cap);
    scan_dr(18, 64'h0, 1, dout);
    s = '0;
    for (int k = 0; k < 20; k++) begin
      idle_step();
      s = (s == 0) ? 18'h1 : lfsr(s);
      chk("R10 pattern output", pin_out, s);
    end

    // R11 count with compaction
    load_ir(8'h0F, cap);
    s = 18'h13579;
    scan_dr(18, {46'h0, s}, 1, dout);
    c = '0;
    for (int k = 0; k < 8; k++) begin
      pin_in = P'(k * 18'h0421 + 3);
      idle_step();
      s = lfsr(s) ^ pin_in;
      c = c + 1;
      chk("R11 count output", pin_out, c);
    end
    scan_dr(18, 64'h0, 1, dout);
    chk("R11 count signature", dout[17:0], s);

    // R12 toggle
    load_ir(8'h11, cap);
    o_exp = o2;
    chk("R12 toggle start", pin_out, o_exp);
    pin_last = '0;
    for (int k = 0; k < 5; k++) begin
      pin_in = P'(18'h2A000 + k * 18'h00F1);
      pin_last = pin_in;
      idle_step();
      o_exp = ~o_exp;
      chk("R12 toggle invert", pin_out, o_exp);
    end
    pin_in = 18'h0;
    scan_dr(36, 64'h0, 0, dout);
    chk("R12 toggle sampled inputs", dout[17:0], pin_last);

    // R2 exhaustive opcode decode
    for (int op = 0; op < 256; op++) begin
      load_ir(8'(op), cap);
      exp_tm = !(^8'(op)) && (8'(op) inside {8'h00, 8'h05, 8'h06, 8'h0A, 8'h0C, 8'h0F, 8'h11});
      chk("R2 opcode decode", test_mode, exp_tm);
    end

    // R13 back to normal
    load_ir(8'hFF, cap);
    func_out = 18'h2468A; func_oe = 0;
    cyc();
    chk("R13 normal pin_out", pin_out, 18'h2468A);
    chk("R13 normal pin_oe", pin_oe, 0);
    chk("R13 normal test_mode", test_mode, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule